// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides one unsigned integer by another over a series of clock cycles. It produces a quotient and a remainder. When start is accepted, the dividend goes into a double-width working register. On each following cycle the working register shifts left by one place. The divisor is then trial-subtracted from its upper half. The carry-out of that subtraction decides the outcome. If the difference is non-negative, it replaces the upper half and a 1 enters the quotient. Otherwise the upper half keeps its shifted value and a 0 enters the quotient.

Because the shift comes before the subtract, the adder only needs to be one bit wider than an operand, and the work takes exactly WIDTH iterations. A divisor of zero is caught when start is accepted. The block then finishes in a single cycle with a flag raised.

The caller raises start with both operands. It then waits for the one-cycle done pulse, after which quotient, remainder and the zero flag can be read. They stay put until the next accepted start.

Top module: `seq_divider`

## Requirements
- R1: For a nonzero divisor, quotient equals floor(dividend / divisor) and remainder equals dividend mod divisor, both unsigned WIDTH-bit values, when done is high.
- R2: For a nonzero divisor, done rises exactly WIDTH clock edges after the edge that accepts start. It stays low while the division runs.
- R3: Whenever done is high for a nonzero divisor, remainder is strictly less than that divisor.
- R4: A zero divisor gives div_zero = 1, an all-ones quotient and remainder equal to the dividend. Done is high right after the accepting edge, with no iterations.
- R5: div_zero is 0 on every result whose divisor was nonzero.
- R6: A start raised while a division is running is ignored. The running division completes with its own operands and produces only one done pulse.
- R7: done is a single-cycle pulse. quotient, remainder and div_zero hold their values from done until the next accepted start.
- R8: A start raised in the same cycle as done is accepted, so divisions can run back to back.
- R9: After reset, done, div_zero, quotient and remainder are all 0.
- R10: Operands with the top bit set are divided correctly. This includes a divisor above half range and a dividend of all ones, which need the one-bit-wider compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; accepted only when idle |
| dividend | input | WIDTH | Numerator, sampled on the accepting edge |
| divisor | input | WIDTH | Denominator, sampled on the accepting edge |
| quotient | output | WIDTH | Integer quotient |
| remainder | output | WIDTH | Remainder of the division |
| done | output | 1 | One-cycle pulse marking a valid result |
| div_zero | output | 1 | Set when the last accepted divisor was zero |

## Verification
The completion pulse of one division and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising start with fresh operands on the very cycle where done is seen. It then judges that the second result is correct and arrives with the normal latency. A zero divisor issued in that slot makes done stay high for a second cycle, and the bench checks this as well. It also raises start midway through a running division and confirms that the first operands' result comes back alone.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             done,
  output logic             div_zero
);
  localparam int CW = $clog2(WIDTH);

  logic [2*WIDTH-1:0] rem_q;
  logic [WIDTH-1:0]   dvs_q, quo_q;
  logic [CW-1:0]      cnt_q;
  logic               busy_q, done_q, dz_q;

  wire [WIDTH:0] trial  = rem_q[2*WIDTH-1:WIDTH-1];
  wire [WIDTH:0] diff   = trial - {1'b0, dvs_q};
  wire           fits   = ~diff[WIDTH];
  wire           accept = start & ~busy_q;
  wire           last   = busy_q && (cnt_q == CW'(WIDTH-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        dz_q  <= (divisor == '0);
        cnt_q <= '0;
        dvs_q <= divisor;
        if (divisor == '0) begin
          quo_q  <= '1;
          rem_q  <= {dividend, {WIDTH{1'b0}}};
          done_q <= 1'b1;
        end else begin
          quo_q  <= '0;
          rem_q  <= {{WIDTH{1'b0}}, dividend};
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        rem_q <= {fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0], rem_q[WIDTH-2:0], 1'b0};
        quo_q <= {quo_q[WIDTH-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q[2*WIDTH-1:WIDTH];
  assign done      = done_q;
  assign div_zero  = dz_q;
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] divisor,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             done,
  input logic             div_zero,
  input logic             busy,
  input logic [WIDTH-1:0] dvs
);
  // R7: single-cycle pulse unless a zero-divisor start lands in the done cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && divisor == '0)) |=> !done);

  a_r4_zero_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (&quotient));

  a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (remainder < dvs));

  a_r2_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
endmodule

bind seq_divider seq_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
  .quotient(quotient), .remainder(remainder), .done(done), .div_zero(div_zero),
  .busy(busy_q), .dvs(dvs_q)
);

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic [W-1:0] quotient, remainder;
  logic done, div_zero;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  seq_divider #(.WIDTH(W)) i_seq_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .done(done), .div_zero(div_zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] exp_q(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b == 0) ? '1 : a / b;
  endfunction
  function automatic logic [W-1:0] exp_r(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b == 0) ? a : a % b;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; leaves at the negedge where done is seen.
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    int lat;
    lat = 0;
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0; dividend = '1; divisor = 32'd3;
    while (!done && lat < 100) begin
      start = poke && (lat == 5 || lat == 20);
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check(b == 0 ? "R4 latency" : "R2 latency", lat, b == 0 ? 0 : W);
    check("R1 quotient", quotient, exp_q(a, b));
    check("R1 remainder", remainder, exp_r(a, b));
    check(b == 0 ? "R4 flag" : "R5 flag", div_zero, b == 0);
    if (b != 0) check("R3 rem<div", remainder < b, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R9 done", done, 0);
    check("R9 flag", div_zero, 0);
    check("R9 quotient", quotient, 0);
    check("R9 remainder", remainder, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_div(32'd74, 32'd8, 0);
    run_div(32'd7, 32'd2, 0);
    run_div(32'd5, 32'd9, 0);
    // R10 top bits set
    run_div(32'hFFFF_FFFF, 32'h8000_0001, 0);
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_div(32'hFFFF_FFFF, 32'd1, 0);
    run_div(32'h8000_0000, 32'hC000_0000, 0);
    // R4 zero divisor
    run_div(32'h1234_5678, 32'd0, 0);
    // R8 back to back: each call starts in the done cycle
    run_div(32'd1000, 32'd7, 0);
    run_div(32'hDEAD_BEEF, 32'd0, 0);
    run_div(32'hDEAD_BEEF, 32'h0001_0000, 0);

    // R7 pulse width and hold
    begin
      logic [W-1:0] q0, r0;
      q0 = quotient; r0 = remainder;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check("R7 done low", done, 0);
        check("R7 q hold", quotient, q0);
        check("R7 r hold", remainder, r0);
      end
    end

    // R6 start ignored while running
    run_div(32'd999_999, 32'd13, 1);
    @(negedge clk);
    check("R6 no extra done", done, 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check("R6 no extra done", done, 0);
    end

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = $urandom();
      b = $urandom() >> ($urandom() % W);
      if (i % 37 == 0) b = 0;
      run_div(a, b, i % 11 == 0);
      if (i % 5 == 0) @(negedge clk);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule